// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns an input address into a real address by descending a radix tree of 64-bit entries held in memory. A walk is launched with a root table base, the number of index bits for the root table and the total size of the address space in bits. At every level the walker takes an index out of the input address, issues exactly one memory read for the selected 8-byte entry, waits for the response and inspects it. A directory entry gives the index width and the base of the next table. A leaf entry ends the walk.

At the end of a walk a single-cycle done pulse reports either a fault with cause bits or a translation. A translation carries the real address, the page size as a bit count, the leaf entry itself and the address the leaf was read from. Table bases with stray low bits are quietly aligned. The set of legal level/width pairs is fixed, and a walk never goes deeper than four levels.

Entry format: bit 63 is the valid flag and bit 62 is the leaf flag. In a directory entry, bits [55:8] hold the next table base, and the base's bits [7:0] are taken as zero. Bits [4:0] give the next level's index width. In a leaf entry, bits [55:12] hold the real page number.

Top module: `radix_walker`

## Requirements
- R1: After reset, `busy`, `mem_req`, `done` and `fault` are all 0.
- R2: For a table with base B, index width N and remaining size S, the entry is read at B + 8 * ((va >> (S - N)) mod 2^N). The root table uses `space_size` as S. After each entry is read, the remaining size drops by that level's N.
- R3: Any of the low N+3 bits that are set in a table base (the root or one taken from a directory entry) are cleared before the entry address is formed. The walk continues normally.
- R4: Only one read is outstanding at a time. `mem_req` stays high with a stable `mem_addr` until a cycle in which `mem_ack` is sampled high, and the entry is taken from `mem_data` in that cycle.
- R5: A read entry with bit 63 clear ends the walk with `fault` = 1 and `cause` = 2'b01 (missing entry).
- R6: Before each read, the level is checked against the legal pairs. Level 0 needs remaining size 52 and width 13. Levels 1 and 2 need width 9. Level 3 needs width 9 or 5. A failed check ends the walk with `fault` = 1 and `cause` = 2'b10 (bad configuration), and no read is issued for that level.
- R7: At a leaf, `pa` is the real page number with its low S bits replaced by the low S bits of `va`, and `page_shift` is S, where S is the remaining size after the leaf level.
- R8: At a leaf, `leaf_pte` is the leaf entry as read and `leaf_addr` is the address it was read from.
- R9: A directory entry at level 3 leads to a level-4 check, which always fails with `cause` = 2'b10. A walk therefore reads at most four entries.
- R10: `done` is high for exactly one cycle, after which the walker is idle. A `start` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a walk (accepted only when idle) |
| va | input | 64 | Address to translate |
| root_base | input | 56 | Root table base address |
| root_bits | input | 5 | Root table index width |
| space_size | input | 7 | Total address space size in bits |
| mem_req | output | 1 | Entry read request |
| mem_addr | output | 56 | Entry read address |
| mem_ack | input | 1 | Read response valid |
| mem_data | input | 64 | Read response entry |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| fault | output | 1 | Walk ended in a fault |
| cause | output | 2 | Fault cause: bit 0 missing entry, bit 1 bad configuration |
| pa | output | 56 | Translated real address |
| page_shift | output | 7 | Page size as a bit count |
| leaf_pte | output | 64 | Leaf entry |
| leaf_addr | output | 56 | Address of the leaf entry |

## Verification
Base alignment and index extraction happen in the same cycle: a directory entry's response yields the next entry address in one step, and the misaligned-base masking is folded into that step. To provoke this, directory entries and the root are given bases with bits set below the alignment boundary, and the walks are run through leaves at several depths. The result is judged by the leaf address and by the real address, which can only come out right if every masked-and-indexed read landed on the aligned table. A start that arrives mid-walk, in the same cycles as pending reads, is also provoked and judged by the unchanged result.

// File: rtl/rw_pkg.sv
package rw_pkg;
  localparam int VA_W  = 64;
  localparam int PA_W  = 56;
  localparam int PTE_W = 64;
  localparam int NB_W  = 5;
  localparam int SZ_W  = 7;
  localparam int LV_W  = 3;

  localparam int PTE_VALID = 63;
  localparam int PTE_LEAF  = 62;
  localparam int NLB_LO    = 8;
  localparam int RPN_LO    = 12;

  localparam int ROOT_SPACE = 52;
  localparam int ROOT_BITS  = 13;
  localparam int MID_BITS   = 9;
  localparam int SMALL_BITS = 5;

  localparam logic [1:0] CAUSE_NOENT  = 2'b01;
  localparam logic [1:0] CAUSE_BADCFG = 2'b10;

  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_WAIT, ST_DONE} walk_st_t;

  // entry address: aligned base plus eight bytes per index step
  function automatic logic [PA_W-1:0] f_entry_addr(input logic [PA_W-1:0] base,
                                                   input logic [NB_W-1:0] nbits,
                                                   input logic [SZ_W-1:0] remain,
                                                   input logic [VA_W-1:0] vaddr);
    logic [SZ_W-1:0] sh;
    logic [VA_W-1:0] idx;
    logic [PA_W-1:0] amask;
    logic [NB_W:0]   abits;
    sh    = remain - SZ_W'(nbits);
    idx   = (vaddr >> sh) & ((VA_W'(1) << nbits) - VA_W'(1));
    abits = {1'b0, nbits} + (NB_W+1)'(3);
    amask = (PA_W'(1) << abits) - PA_W'(1);
    return (base & ~amask) + PA_W'(idx << 3);
  endfunction

  // legal level / width pairs
  function automatic logic f_level_ok(input logic [LV_W-1:0] lvl,
                                      input logic [SZ_W-1:0] remain,
                                      input logic [NB_W-1:0] nbits);
    case (lvl)
      LV_W'(0): return remain == SZ_W'(ROOT_SPACE) && nbits == NB_W'(ROOT_BITS);
      LV_W'(1),
      LV_W'(2): return nbits == NB_W'(MID_BITS);
      LV_W'(3): return nbits == NB_W'(MID_BITS) || nbits == NB_W'(SMALL_BITS);
      default:  return 1'b0;
    endcase
  endfunction

  // real address: page number high part, input address low part
  function automatic logic [PA_W-1:0] f_form_pa(input logic [PA_W-1:RPN_LO] rpn,
                                                input logic [PA_W-1:0] vlow,
                                                input logic [SZ_W-1:0] remain);
    logic [PA_W-1:0] mask;
    logic [PA_W-1:0] page;
    mask = (PA_W'(1) << remain) - PA_W'(1);
    page = {rpn, {RPN_LO{1'b0}}};
    return (page & ~mask) | (vlow & mask);
  endfunction
endpackage

// File: rtl/rw_cfg_check.sv
module rw_cfg_check
  import rw_pkg::*;
#(
  parameter int LVW        = LV_W,
  parameter int SZW        = SZ_W,
  parameter int NBW        = NB_W,
  parameter int MAX_LEVELS = 4
) (
  input  logic [LVW-1:0] level,
  input  logic [SZW-1:0] remain,
  input  logic [NBW-1:0] nbits,
  output logic           cfg_ok
);
  localparam logic [LVW-1:0] LAST = LVW'(MAX_LEVELS);

  always_comb begin
    cfg_ok = (level < LAST) && f_level_ok(LV_W'(level), SZ_W'(remain), NB_W'(nbits));
  end
endmodule

// File: rtl/rw_index_gen.sv
module rw_index_gen
  import rw_pkg::*;
(
  input  logic [PA_W-1:0] base,
  input  logic [NB_W-1:0] nbits,
  input  logic [SZ_W-1:0] remain,
  input  logic [VA_W-1:0] vaddr,
  output logic [PA_W-1:0] ent_addr
);
  always_comb ent_addr = f_entry_addr(base, nbits, remain, vaddr);
endmodule

// File: rtl/rw_leaf_form.sv
module rw_leaf_form
  import rw_pkg::*;
(
  input  logic [PA_W-1:RPN_LO] rpn,
  input  logic [PA_W-1:0]      vlow,
  input  logic [SZ_W-1:0]      remain,
  output logic [PA_W-1:0]      real_addr
);
  always_comb real_addr = f_form_pa(rpn, vlow, remain);
endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import rw_pkg::*;
#(
  parameter int MAX_LEVELS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VA_W-1:0]  va,
  input  logic [PA_W-1:0]  root_base,
  input  logic [NB_W-1:0]  root_bits,
  input  logic [SZ_W-1:0]  space_size,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_ack,
  input  logic [PTE_W-1:0] mem_data,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic [1:0]       cause,
  output logic [PA_W-1:0]  pa,
  output logic [SZ_W-1:0]  page_shift,
  output logic [PTE_W-1:0] leaf_pte,
  output logic [PA_W-1:0]  leaf_addr
);
  walk_st_t        state;
  logic [VA_W-1:0] va_q;
  logic [NB_W-1:0] bits_q;
  logic [SZ_W-1:0] size_q;
  logic [LV_W-1:0] level_q;
  logic [PA_W-1:0] ent_addr_q;

  logic            fault_q;
  logic [1:0]      cause_q;
  logic [PA_W-1:0] pa_q;
  logic [SZ_W-1:0] shift_q;
  logic [PTE_W-1:0] pte_q;
  logic [PA_W-1:0] laddr_q;

  // named internal events
  logic            ev_accept, ev_resp, ev_noent, ev_leaf, ev_descend;
  logic            ev_cfg_pass, ev_cfg_reject, cfg_ok;
  logic [SZ_W-1:0] remain_next;
  logic [PA_W-1:0] gen_base, gen_addr, leaf_pa;
  logic [NB_W-1:0] gen_bits;
  logic [SZ_W-1:0] gen_remain;
  logic [VA_W-1:0] gen_va;

  assign remain_next   = size_q - SZ_W'(bits_q);
  assign ev_accept     = (state == ST_IDLE) && start;
  assign ev_resp       = (state == ST_WAIT) && mem_ack;
  assign ev_noent      = ev_resp && !mem_data[PTE_VALID];
  assign ev_leaf       = ev_resp && mem_data[PTE_VALID] && mem_data[PTE_LEAF];
  assign ev_descend    = ev_resp && mem_data[PTE_VALID] && !mem_data[PTE_LEAF];
  assign ev_cfg_pass   = (state == ST_CHECK) && cfg_ok;
  assign ev_cfg_reject = (state == ST_CHECK) && !cfg_ok;

  // address generator input: root when idle, directory entry otherwise
  always_comb begin
    if (state == ST_IDLE) begin
      gen_base   = root_base;
      gen_bits   = root_bits;
      gen_remain = space_size;
      gen_va     = va;
    end else begin
      gen_base   = {mem_data[PA_W-1:NLB_LO], {NLB_LO{1'b0}}};
      gen_bits   = mem_data[NB_W-1:0];
      gen_remain = remain_next;
      gen_va     = va_q;
    end
  end

  rw_index_gen u_idx (
    .base    (gen_base),
    .nbits   (gen_bits),
    .remain  (gen_remain),
    .vaddr   (gen_va),
    .ent_addr(gen_addr)
  );

  rw_cfg_check #(.LVW(LV_W), .SZW(SZ_W), .NBW(NB_W), .MAX_LEVELS(MAX_LEVELS)) u_cfg (
    .level (level_q),
    .remain(size_q),
    .nbits (bits_q),
    .cfg_ok(cfg_ok)
  );

  rw_leaf_form u_leaf (
    .rpn      (mem_data[PA_W-1:RPN_LO]),
    .vlow     (va_q[PA_W-1:0]),
    .remain   (remain_next),
    .real_addr(leaf_pa)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      va_q       <= '0;
      bits_q     <= '0;
      size_q     <= '0;
      level_q    <= '0;
      ent_addr_q <= '0;
      fault_q    <= 1'b0;
      cause_q    <= '0;
      pa_q       <= '0;
      shift_q    <= '0;
      pte_q      <= '0;
      laddr_q    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (ev_accept) begin
          va_q       <= va;
          bits_q     <= root_bits;
          size_q     <= space_size;
          level_q    <= '0;
          ent_addr_q <= gen_addr;
          state      <= ST_CHECK;
        end
        ST_CHECK: begin
          if (ev_cfg_pass) begin
            state <= ST_WAIT;
          end else begin
            fault_q <= 1'b1;
            cause_q <= CAUSE_BADCFG;
            pa_q    <= '0;
            shift_q <= '0;
            pte_q   <= '0;
            laddr_q <= '0;
            state   <= ST_DONE;
          end
        end
        ST_WAIT: begin
          if (ev_noent) begin
            fault_q <= 1'b1;
            cause_q <= CAUSE_NOENT;
            pa_q    <= '0;
            shift_q <= '0;
            pte_q   <= '0;
            laddr_q <= '0;
            state   <= ST_DONE;
          end else if (ev_leaf) begin
            fault_q <= 1'b0;
            cause_q <= '0;
            pa_q    <= leaf_pa;
            shift_q <= remain_next;
            pte_q   <= mem_data;
            laddr_q <= ent_addr_q;
            state   <= ST_DONE;
          end else if (ev_descend) begin
            bits_q     <= mem_data[NB_W-1:0];
            size_q     <= remain_next;
            level_q    <= level_q + LV_W'(1);
            ent_addr_q <= gen_addr;
            state      <= ST_CHECK;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req    = (state == ST_WAIT);
  assign mem_addr   = ent_addr_q;
  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_DONE);
  assign fault      = fault_q;
  assign cause      = cause_q;
  assign pa         = pa_q;
  assign page_shift = shift_q;
  assign leaf_pte   = pte_q;
  assign leaf_addr  = laddr_q;

  // R4: a pending read holds its request and address
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R4: never a request and a done at once
  p_req_done_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req, done}));

  // R5: invalid entry ends in missing-entry fault
  p_noent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_noent |=> (done && fault && cause == CAUSE_NOENT));

  // R6: rejected configuration issues no read and faults
  p_cfg_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cfg_reject |=> (done && !mem_req && fault && cause == CAUSE_BADCFG));

  // R7: leaf gives a fault-free completion
  p_leaf_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_leaf |=> (done && !fault));

  // R9: depth never exceeds the level cap
  p_level_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LV_W'(MAX_LEVELS));

  // R10: single-cycle done, then idle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R10: start during a walk leaves the captured address alone
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(va_q));
endmodule

// File: tb/sim_radix_walker.sv
`timescale 1ns/1ps
module sim_radix_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] va = '0;
  logic [55:0] root_base = '0;
  logic [4:0]  root_bits = '0;
  logic [6:0]  space_size = '0;
  logic        mem_req;
  logic [55:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_data = '0;
  logic        busy, done, fault;
  logic [1:0]  cause;
  logic [55:0] pa, leaf_addr;
  logic [6:0]  page_shift;
  logic [63:0] leaf_pte;

  always #5 clk = ~clk;

  radix_walker u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .va(va), .root_base(root_base),
    .root_bits(root_bits), .space_size(space_size), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data), .busy(busy),
    .done(done), .fault(fault), .cause(cause), .pa(pa), .page_shift(page_shift),
    .leaf_pte(leaf_pte), .leaf_addr(leaf_addr)
  );

  // memory model
  logic [63:0] mem [logic [55:0]];
  int          lat = 0;
  int          wait_cnt = 0;
  int          rd_cnt = 0;
  int          moves = 0;
  logic [55:0] first_addr = '0;

  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (wait_cnt == 0) first_addr = mem_addr;
      else if (mem_addr !== first_addr) moves++;
      if (wait_cnt >= lat) begin
        mem_data = mem.exists(mem_addr) ? mem[mem_addr] : 64'd0;
        mem_ack  = 1'b1;
        rd_cnt++;
        wait_cnt = 0;
      end else wait_cnt++;
    end
  end

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  localparam logic [55:0] ROOT = 56'h01_0000;
  localparam logic [55:0] RPN  = 56'h5A_5A5A_5A5A_5000;
  localparam logic [63:0] LEAF_ENT = {2'b11, 6'b0, RPN};

  function automatic logic [55:0] tb_base(input int lvl);
    return 56'h10_0000 * 56'(lvl + 1);
  endfunction

  function automatic logic [55:0] tb_ea(input logic [55:0] b, input int nb, input int sz,
                                        input logic [63:0] v);
    logic [63:0] q;
    logic [63:0] lim;
    logic [55:0] align;
    q     = v >> (sz - nb);
    lim   = 64'd1 << nb;
    align = 56'd1 << (nb + 3);
    return (b - (b % align)) + 56'((q % lim) * 64'd8);
  endfunction

  logic [55:0] exp_pa, exp_addr;
  logic [6:0]  exp_shift;

  // build tree for one vector and compute expected leaf values
  task automatic build(input logic [63:0] v, input int leaf_lvl, input int l3b,
                       input bit mis, input int inv);
    logic [55:0] b, nb, ea;
    logic [63:0] msk;
    int bits, sz, nbits;
    mem.delete();
    b = ROOT; bits = 13; sz = 52;
    exp_pa = '0; exp_addr = '0; exp_shift = '0;
    for (int lvl = 0; lvl < 4; lvl++) begin
      ea = tb_ea(b, bits, sz, v);
      if (lvl == inv) break;
      if (lvl == leaf_lvl) begin
        mem[ea]   = LEAF_ENT;
        exp_addr  = ea;
        exp_shift = 7'(sz - bits);
        msk       = (64'd1 << (sz - bits)) - 64'd1;
        exp_pa    = (RPN & ~msk[55:0]) | (v[55:0] & msk[55:0]);
        break;
      end
      nbits = (lvl == 2) ? l3b : 9;
      nb    = tb_base(lvl + 1) | (mis ? 56'hA00 : 56'h0);
      mem[ea] = {1'b1, 1'b0, 6'b0, nb[55:8], 3'b0, 5'(nbits)};
      sz   = sz - bits;
      b    = tb_base(lvl + 1);
      bits = nbits;
    end
  endtask

  logic        g_fault;
  logic [1:0]  g_cause;
  logic [55:0] g_pa, g_laddr;
  logic [6:0]  g_shift;
  logic [63:0] g_pte;
  int          g_reads, g_moves;

  task automatic walk(input logic [63:0] v, input logic [55:0] rb, input logic [4:0] rbits,
                      input logic [6:0] rsize, input int latency, input bit poke);
    int r0, m0;
    bit seen;
    lat = latency;
    r0 = rd_cnt; m0 = moves;
    @(negedge clk);
    start = 1'b1; va = v; root_base = rb; root_bits = rbits; space_size = rsize;
    @(negedge clk);
    start = 1'b0;
    seen = 1'b0;
    for (int c = 0; c < 5000; c++) begin
      if (poke && c == 1) begin start = 1'b1; va = ~v; root_base = '0; end
      if (poke && c == 2) start = 1'b0;
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    start = 1'b0;
    if (!seen) chk("R10 watchdog: done never seen", 64'd0, 64'd1);
    g_fault = fault; g_cause = cause; g_pa = pa; g_shift = page_shift;
    g_pte = leaf_pte; g_laddr = leaf_addr;
    g_reads = rd_cnt - r0; g_moves = moves - m0;
    @(negedge clk);
    chk("R10 done lasts one cycle", {63'd0, done}, 64'd0);
    chk("R10 idle after done", {63'd0, busy}, 64'd0);
  endtask

  typedef struct packed {
    logic [63:0] v;
    logic [2:0]  leaf;
    logic [4:0]  l3b;
    logic        mis;
    logic [2:0]  inv;
    logic        ef;
    logic [1:0]  ec;
    logic [2:0]  rd;
  } row_t;

  localparam int NROWS = 11;
  localparam row_t ROWS [NROWS] = '{
    '{64'h000F_EDCB_A987_6543, 3'd3, 5'd9, 1'b0, 3'd7, 1'b0, 2'd0, 3'd4},
    '{64'h0001_2345_6789_ABCD, 3'd3, 5'd5, 1'b0, 3'd7, 1'b0, 2'd0, 3'd4},
    '{64'h000A_5A5A_F0F0_1234, 3'd2, 5'd9, 1'b0, 3'd7, 1'b0, 2'd0, 3'd3},
    '{64'h0003_C3C3_7777_0FED, 3'd1, 5'd9, 1'b0, 3'd7, 1'b0, 2'd0, 3'd2},
    '{64'h000E_0123_4567_89AB, 3'd0, 5'd9, 1'b0, 3'd7, 1'b0, 2'd0, 3'd1},
    '{64'h0007_7654_3210_FEDC, 3'd3, 5'd9, 1'b1, 3'd7, 1'b0, 2'd0, 3'd4},
    '{64'h0002_2222_3333_4444, 3'd3, 5'd9, 1'b0, 3'd0, 1'b1, 2'd1, 3'd1},
    '{64'h0009_8765_ABCD_0123, 3'd3, 5'd9, 1'b0, 3'd2, 1'b1, 2'd1, 3'd3},
    '{64'h0004_4444_5555_6666, 3'd3, 5'd7, 1'b0, 3'd7, 1'b1, 2'd2, 3'd3},
    '{64'h000B_BBBB_1111_2222, 3'd4, 5'd9, 1'b0, 3'd7, 1'b1, 2'd2, 3'd4},
    '{64'h000C_1357_9BDF_2468, 3'd2, 5'd9, 1'b1, 3'd7, 1'b0, 2'd0, 3'd3}
  };

  initial begin
    #1_000_000;
    chk("R10 global watchdog expired", 64'd0, 64'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy at reset", {63'd0, busy}, 64'd0);
    chk("R1 mem_req at reset", {63'd0, mem_req}, 64'd0);
    chk("R1 done at reset", {63'd0, done}, 64'd0);
    chk("R1 fault at reset", {63'd0, fault}, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NROWS; i++) begin
      build(ROWS[i].v, int'(ROWS[i].leaf), int'(ROWS[i].l3b), ROWS[i].mis, int'(ROWS[i].inv));
      walk(ROWS[i].v, ROWS[i].mis ? (ROOT | 56'h1A08) : ROOT, 5'd13, 7'd52, i % 4, 1'b0);
      chk($sformatf("R5/R6/R9 fault row %0d", i), {63'd0, g_fault}, {63'd0, ROWS[i].ef});
      chk($sformatf("R5/R6/R9 cause row %0d", i), {62'd0, g_cause}, {62'd0, ROWS[i].ec});
      chk($sformatf("R6/R9 read count row %0d", i), 64'(g_reads), 64'(ROWS[i].rd));
      chk($sformatf("R4 address stable row %0d", i), 64'(g_moves), 64'd0);
      if (!ROWS[i].ef) begin
        chk($sformatf("R7/R2/R3 real address row %0d", i), {8'd0, g_pa}, {8'd0, exp_pa});
        chk($sformatf("R7 page shift row %0d", i), {57'd0, g_shift}, {57'd0, exp_shift});
        chk($sformatf("R8 leaf entry row %0d", i), g_pte, LEAF_ENT);
        chk($sformatf("R8/R2/R3 leaf address row %0d", i), {8'd0, g_laddr}, {8'd0, exp_addr});
      end
    end

    // R6: root with wrong total size, no read at all
    walk(64'h1234, ROOT, 5'd13, 7'd48, 0, 1'b0);
    chk("R6 root size 48 cause", {62'd0, g_cause}, 64'd2);
    chk("R6 root size 48 no read", 64'(g_reads), 64'd0);
    // R6: root with wrong index width
    walk(64'h1234, ROOT, 5'd12, 7'd52, 0, 1'b0);
    chk("R6 root width 12 fault", {63'd0, g_fault}, 64'd1);
    chk("R6 root width 12 no read", 64'(g_reads), 64'd0);

    // R10: start while busy is ignored
    build(ROWS[0].v, 3, 9, 1'b0, 7);
    walk(ROWS[0].v, ROOT, 5'd13, 7'd52, 3, 1'b1);
    chk("R10 busy start ignored pa", {8'd0, g_pa}, {8'd0, exp_pa});
    chk("R10 busy start ignored reads", 64'(g_reads), 64'd4);
    repeat (3) @(negedge clk);
    chk("R10 no walk after ignored start", {63'd0, busy}, 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule